// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Input Interface

This block is the digital front end of a 12-bit parallel-load converter. The data bus is written in two parts. The low eight bits go into a lower input register when the low-byte select and the write strobe are both low. The top four bits go into an upper input register when the high-byte select and the write strobe are both low. A separate load strobe, also qualified by the write strobe, copies the assembled 12-bit word into the output holding register. That register drives the converter code. If all strobes are low together, data flows straight from the bus to the output code.

All controls and the data bus are brought into the system clock domain through two synchronizer stages. The latches are then emulated with clock-enabled registers. A latch is open on every cycle in which its synchronized enable condition holds. A clear input and the power-on reset both force every register to zero. The clear overrides any load on the same cycle. A one-cycle update pulse marks each change of the output code.

Top module: `dbl_buf_dac_if`

## Requirements
- R1: After the power-on reset (`rst_n` low), or after any later reset, `code` is 0x000, `upd` is 0, and both input registers hold zero. A load transfer straight after reset therefore gives 0x000.
- R2: When `lsb_sel_n` and `wr_n` are both low, the lower input register takes `din[7:0]`. In every other case it keeps its value.
- R3: When `msb_sel_n` and `wr_n` are both low, the upper input register takes `din[11:8]`. In every other case it keeps its value.
- R4: When `ld_n` and `wr_n` are both low, `code` takes the word {upper, lower} from the input registers. If `wr_n` is high or `ld_n` is high, `code` keeps its value.
- R5: When `lsb_sel_n`, `msb_sel_n`, `wr_n` and `ld_n` are all low, `code` follows `din` directly, including later changes of `din`.
- R6: When `clr_n` is low, both input registers and `code` become zero on that cycle, whatever the other controls are.
- R7: A change on the inputs made before rising edge N shows on `code` after rising edge N+2 and not earlier.
- R8: `upd` is high for exactly one cycle each time `code` changes value, and it is low in every other cycle.
- R9: The two input halves can be written in either order with the same result. Writing one half never changes the other half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| lsb_sel_n | input | 1 | Low-byte select, active low |
| msb_sel_n | input | 1 | High-nibble select, active low |
| wr_n | input | 1 | Write strobe shared by all transfers, active low |
| ld_n | input | 1 | Transfer strobe from input registers to output code, active low |
| clr_n | input | 1 | Clear of all registers, active low |
| din | input | 12 | Parallel data bus |
| code | output | 12 | Output holding register, the converter code |
| upd | output | 1 | One-cycle pulse on each change of `code` |

## Verification
The hardest state to reach from the ports is a clear that arrives while a load is in progress. The clear must still win on the synchronized cycle where both are active. The table reaches this state in two ways. It drops `clr_n` during full flow-through, and it drops `clr_n` while the low-byte write is held. In both cases the following transfer must give zero, which shows that the cleared input halves were not loaded. The flow-through latency is checked edge by edge in a directed step, so both a missing synchronizer stage and an extra one are caught.

// File: rtl/dacif_pkg.sv
`timescale 1ns/1ps
package dacif_pkg;

  localparam int DEF_DATA_W = 12;
  localparam int DEF_LO_W   = 8;
  localparam int DEF_STAGES = 2;

  // synchronized control bundle, all active low
  typedef struct packed {
    logic lsb_n;
    logic msb_n;
    logic wr_n;
    logic ld_n;
    logic clr_n;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
  localparam logic [CTL_W-1:0] CTL_IDLE = '1;

endpackage

// File: rtl/dacif_rst_sync.sv
`timescale 1ns/1ps
module dacif_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/dacif_sync.sv
`timescale 1ns/1ps
module dacif_sync #(
  parameter int          W       = 5,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] tap [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] prv;
    logic [W-1:0] r;

    if (g == 0) begin : g_first
      assign prv = d;
    end else begin : g_next
      assign prv = tap[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= RST_VAL;
      end else begin
        r <= prv;
      end
    end

    assign tap[g] = r;
  end

  assign q = tap[STAGES-1];

endmodule

// File: rtl/dacif_latch.sv
`timescale 1ns/1ps
module dacif_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         open,
  input  logic [W-1:0] d,
  output logic [W-1:0] view,
  output logic [W-1:0] q
);

  logic en;

  // transparent view: what a real latch would show this cycle
  always_comb begin
    if (clr) begin
      view = '0;
    end else if (open) begin
      view = d;
    end else begin
      view = q;
    end
    en = clr | open;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= view;
    end
  end

endmodule

// File: rtl/dbl_buf_dac_if.sv
`timescale 1ns/1ps
module dbl_buf_dac_if
  import dacif_pkg::*;
#(
  parameter int DATA_W      = DEF_DATA_W,
  parameter int LO_W        = DEF_LO_W,
  parameter int SYNC_STAGES = DEF_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lsb_sel_n,
  input  logic              msb_sel_n,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic              clr_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] code,
  output logic              upd
);

  localparam int HI_W = DATA_W - LO_W;

  logic              rst_sync_n;
  ctl_t              raw_ctl;
  logic [CTL_W-1:0]  s_ctl_v;
  ctl_t              s_ctl;
  logic [DATA_W-1:0] s_din;

  logic              lo_open;
  logic              hi_open;
  logic              dac_open;
  logic              clr;

  logic [LO_W-1:0]   lo_view;
  logic [LO_W-1:0]   lo_q;
  logic [HI_W-1:0]   hi_view;
  logic [HI_W-1:0]   hi_q;
  logic [DATA_W-1:0] dac_view;
  logic [DATA_W-1:0] dac_q;
  logic              upd_d;
  logic              upd_q;

  dacif_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    raw_ctl.lsb_n = lsb_sel_n;
    raw_ctl.msb_n = msb_sel_n;
    raw_ctl.wr_n  = wr_n;
    raw_ctl.ld_n  = ld_n;
    raw_ctl.clr_n = clr_n;
  end

  dacif_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (raw_ctl),
    .q     (s_ctl_v)
  );

  // data runs through the same depth so it stays aligned with its strobes
  dacif_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_din_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (din),
    .q     (s_din)
  );

  assign s_ctl = ctl_t'(s_ctl_v);

  always_comb begin
    clr      = ~s_ctl.clr_n;
    lo_open  = ~s_ctl.lsb_n & ~s_ctl.wr_n;
    hi_open  = ~s_ctl.msb_n & ~s_ctl.wr_n;
    dac_open = ~s_ctl.ld_n  & ~s_ctl.wr_n;
  end

  dacif_latch #(.W(LO_W)) u_lo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (clr),
    .open  (lo_open),
    .d     (s_din[LO_W-1:0]),
    .view  (lo_view),
    .q     (lo_q)
  );

  dacif_latch #(.W(HI_W)) u_hi (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (clr),
    .open  (hi_open),
    .d     (s_din[DATA_W-1:LO_W]),
    .view  (hi_view),
    .q     (hi_q)
  );

  // second stage sees the transparent view of the first: flow-through path
  dacif_latch #(.W(DATA_W)) u_dac (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (clr),
    .open  (dac_open),
    .d     ({hi_view, lo_view}),
    .view  (dac_view),
    .q     (dac_q)
  );

  always_comb begin
    upd_d = (dac_view != dac_q);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      upd_q <= 1'b0;
    end else begin
      upd_q <= upd_d;
    end
  end

  assign code = dac_q;
  assign upd  = upd_q;

endmodule

// File: rtl/dacif_chk.sv
`timescale 1ns/1ps
module dacif_chk #(
  parameter int DATA_W = 12,
  parameter int LO_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              c_lsb_n,
  input logic              c_msb_n,
  input logic              c_wr_n,
  input logic              c_ld_n,
  input logic              c_clr_n,
  input logic [DATA_W-1:0] c_din,
  input logic [LO_W-1:0]   lo,
  input logic [DATA_W-LO_W-1:0] hi,
  input logic [DATA_W-1:0] code,
  input logic              upd
);

  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (c_clr_n && (c_lsb_n || c_wr_n)) |=> $stable(lo)); // R2
  AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (c_clr_n && !c_lsb_n && !c_wr_n) |=> (lo == $past(c_din[LO_W-1:0]))); // R2
  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (c_clr_n && (c_msb_n || c_wr_n)) |=> $stable(hi)); // R3
  AST_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (c_clr_n && !c_msb_n && !c_wr_n) |=> (hi == $past(c_din[DATA_W-1:LO_W]))); // R3
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (c_clr_n && (c_ld_n || c_wr_n)) |=> $stable(code)); // R4
  AST_FLOW_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (c_clr_n && !c_lsb_n && !c_msb_n && !c_wr_n && !c_ld_n) |=> (code == $past(c_din))); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !c_clr_n |=> (lo == '0 && hi == '0 && code == '0)); // R6
  AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (code != $past(code)) |-> upd); // R8
  AST_NO_IDLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> (code != $past(code))); // R8

endmodule

bind dbl_buf_dac_if dacif_chk #(.DATA_W(DATA_W), .LO_W(LO_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .c_lsb_n (s_ctl.lsb_n),
  .c_msb_n (s_ctl.msb_n),
  .c_wr_n  (s_ctl.wr_n),
  .c_ld_n  (s_ctl.ld_n),
  .c_clr_n (s_ctl.clr_n),
  .c_din   (s_din),
  .lo      (lo_q),
  .hi      (hi_q),
  .code    (code),
  .upd     (upd)
);

// File: tb/sim_dbl_buf_dac_if.sv
`timescale 1ns/1ps
module sim_dbl_buf_dac_if;

  logic        clk;
  logic        rst_n;
  logic        lsb_sel_n, msb_sel_n, wr_n, ld_n, clr_n;
  logic [11:0] din;
  logic [11:0] code;
  logic        upd;

  int n_chk;
  int n_fail;
  int pulses;

  dbl_buf_dac_if u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .lsb_sel_n (lsb_sel_n),
    .msb_sel_n (msb_sel_n),
    .wr_n      (wr_n),
    .ld_n      (ld_n),
    .clr_n     (clr_n),
    .din       (din),
    .code      (code),
    .upd       (upd)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {lsb_n,msb_n,wr_n,ld_n,clr_n}, din, expected code
  localparam int NV = 19;
  localparam logic [28:0] VEC [NV] = '{
    {5'b11111, 12'hABC, 12'h000},  // idle, nothing moves (R4)
    {5'b01011, 12'h3C5, 12'h000},  // low byte first (R2)
    {5'b10011, 12'h7A0, 12'h000},  // then high nibble (R3)
    {5'b11001, 12'hFFF, 12'h7C5},  // transfer (R4)
    {5'b11101, 12'h123, 12'h7C5},  // load strobe without write: hold (R4)
    {5'b10011, 12'h9FF, 12'h7C5},  // reverse order: high first (R9)
    {5'b01011, 12'h012, 12'h7C5},  // then low byte (R9)
    {5'b01111, 12'hEEE, 12'h7C5},  // select without write: no load (R2)
    {5'b11001, 12'h000, 12'h912},  // transfer shows untouched halves (R9)
    {5'b00001, 12'h5A6, 12'h5A6},  // flow-through (R5)
    {5'b00001, 12'h0F0, 12'h0F0},  // flow-through follows bus (R5)
    {5'b00101, 12'hAAA, 12'h0F0},  // write high: all hold (R4)
    {5'b00000, 12'hFFF, 12'h000},  // clear during flow-through (R6)
    {5'b11001, 12'hFFF, 12'h000},  // input halves were cleared (R6)
    {5'b01011, 12'h0AB, 12'h000},  // low byte load (R2)
    {5'b01010, 12'h0CD, 12'h000},  // clear while low byte loading (R6)
    {5'b11001, 12'h000, 12'h000},  // proves low half cleared (R6)
    {5'b00011, 12'h456, 12'h000},  // both halves together (R2, R3)
    {5'b11001, 12'h000, 12'h456}   // transfer (R4)
  };

  task automatic chk(input string req, input int step, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s step %0d: actual %h expected %h", req, step, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] c, input logic [11:0] d);
    {lsb_sel_n, msb_sel_n, wr_n, ld_n, clr_n} = c;
    din = d;
  endtask

  task automatic hold_count(input int n);
    pulses = 0;
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      if (upd) pulses++;
    end
  endtask

  initial begin
    logic [11:0] prev_exp;
    n_chk  = 0;
    n_fail = 0;
    rst_n  = 1'b0;
    drive(5'b11111, 12'h000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 code", 0, code, 12'h000);
    chk("R1 upd", 0, {11'd0, upd}, 12'h000);

    prev_exp = 12'h000;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][28:24], VEC[i][23:12]);
      hold_count(5);
      chk("table code (R2,R3,R4,R5,R6,R9)", i, code, VEC[i][11:0]);
      chk("R8 pulse count", i, 12'(pulses), (VEC[i][11:0] != prev_exp) ? 12'd1 : 12'd0);
      prev_exp = VEC[i][11:0];
    end

    // R7: latency, code is 0x456 here
    drive(5'b00001, 12'h789);
    @(posedge clk); @(negedge clk);
    chk("R7 edge N", 1, code, 12'h456);
    @(posedge clk); @(negedge clk);
    chk("R7 edge N+1", 2, code, 12'h456);
    @(posedge clk); @(negedge clk);
    chk("R7 edge N+2", 3, code, 12'h789);
    chk("R8 pulse on change", 3, {11'd0, upd}, 12'h001);
    @(posedge clk); @(negedge clk);
    chk("R8 pulse one cycle", 4, {11'd0, upd}, 12'h000);
    drive(5'b11111, 12'h000);
    hold_count(4);

    // R1: reset mid-run clears outputs and input halves
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 code mid reset", 5, code, 12'h000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(5'b11001, 12'hFFF);
    hold_count(5);
    chk("R1 halves zero after reset", 6, code, 12'h000);
    chk("R8 no pulse without change", 6, 12'(pulses), 12'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100us;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule